// File: doc/BRIEF.md
# Serial Command Busy-Lock Arbiter

This block sits between the register-write path of a serial line controller (LIN or UART framing) and the shifter that sends bytes. It decides which register writes and which commands take effect, and when they take effect. A transmit-start indication from the shifter raises a busy flag. A byte-done indication lowers it. While busy is high, the configuration registers are frozen. Only three kinds of command can act during that time: an abort that waits for the byte to finish, a kill that acts at once, and a software reset that acts at once. Any other command written during busy is dropped and sets a sticky overrun flag.

The block holds the six lockable registers and presents them as one flat image. They are the control register's spare field, two baud-divisor bytes, a length, an identifier and a data byte. It also provides per-register write enables for any neighbour that shadows them. Every strobe it produces is a single-cycle registered pulse, which appears in the cycle after the write or indication that caused it.

Top module: `cmd_lock_arbiter`

## Requirements
- R1: `busy` is 0 after reset. It is 1 from the cycle after a `txStart` sample. It returns to 0 in the cycle after a `byteDone` sample. When `txStart` and `byteDone` arrive in the same cycle, `busy` stays 1.
- R2: Addresses 0 to 5 are the lockable registers, in this order: control, baud low, baud high, length, identifier, data. While `busy` is 1, writes to addresses 1 to 5 are ignored: `regWrEn` stays 0 and `regImage` does not change. While `busy` is 0, a write to address i raises `regWrEn[i]` in the same cycle, and byte i of `regImage` holds the new value from the next cycle on.
- R3: Control-register layout: bit 7 is the software-reset bit (not stored), bits 6:4 are the spare field, bit 3 is the enable bit and bits 2:0 are the command. While `busy` is 1, the spare field ignores writes. The enable and command fields accept any control write that is not rejected.
- R4: A control write made while `busy` is 0 launches a command when the enable bit is 1, the command MSB is 1 and bit 7 is 0. The launch shows as `cmdLaunch` high for one cycle, in the next cycle, with `launchCode` equal to the command field.
- R5: While `busy` is 1, a control write that is not a reset, not a kill and has command bits [1:0] not equal to 00 is rejected. It sets `ovrErr`, produces no launch, leaves `busy` high and leaves the control image unchanged.
- R6: A kill is a control write with the enable bit at 0 or the command MSB at 0. In the next cycle it pulses `killStrobe` and clears `busy`. It also cancels any pending abort, so a later `byteDone` gives no `abortStrobe`.
- R7: A control write while busy with enable 1 and command 100 is an abort. It produces no strobe until the byte ends. `abortStrobe` pulses in the cycle after the `byteDone` sample, and this includes a `byteDone` in the same cycle as the abort write.
- R8: A control write with bit 7 at 1 pulses `resetStrobe` in the next cycle, whether or not the block is busy. It clears `busy`, any pending abort, `ovrErr` and the whole `regImage`, and it takes priority over a `txStart` in the same cycle.
- R9: `ovrErr` stays set until a write of 1 to bit 0 of address 6 clears it. A write of 0 to that bit leaves it set.
- R10: After reset, all strobes, `ovrErr` and `regImage` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0-5 lockable, 6 error) |
| wrData | input | 8 | Write data |
| txStart | input | 1 | Shifter begins transmitting a byte |
| byteDone | input | 1 | Shifter finished the current byte |
| busy | output | 1 | Transmission in progress, registers locked |
| regWrEn | output | 6 | Per-register accepted-write enables |
| regImage | output | 48 | Lockable register contents, control in bits 7:0 |
| cmdLaunch | output | 1 | Command launch pulse |
| launchCode | output | 3 | Command code that goes with `cmdLaunch` |
| killStrobe | output | 1 | Immediate kill pulse |
| resetStrobe | output | 1 | Software reset pulse |
| abortStrobe | output | 1 | Deferred abort pulse at end of byte |
| ovrErr | output | 1 | Sticky rejected-command flag |

## Verification
The hardest cases to reach are the ones where a pending abort meets a later event. In one, a kill cancels the abort before the byte ends. In the other, the abort write and `byteDone` land on the same edge. The stimulus starts a byte and queues an abort. It then sends a kill and only afterwards a `byteDone`, and the expectation is that no abort pulse appears. A separate sequence starts a new byte and writes the abort together with `byteDone` in one cycle. A `txStart` coinciding with `byteDone`, and a reset coinciding with `txStart`, are driven on the same edges in the same way.

// File: rtl/cmd_lock_pkg.sv
package cmd_lock_pkg;
  // control register field positions (decoded by the arbiter)
  localparam int RST_BIT = 7;
  localparam int EN_BIT  = 3;
  localparam int CMD_MSB = 2;
  localparam int OVR_BIT = 0;
  localparam logic [7:0] FIELD_MASK = 8'h0F;
  localparam logic [7:0] SPARE_MASK = 8'h70;
  localparam int CTRL_IDX = 0;
  localparam int ERR_ADDR = 6;

  typedef struct packed {
    logic lockOpen;
    logic fieldWr;
    logic swReset;
    logic ovrSet;
    logic ovrClr;
  } lockStrb_t;
endpackage

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import cmd_lock_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txStart,
  input  logic              byteDone,
  output logic              busy,
  output logic              cmdLaunch,
  output logic [2:0]        launchCode,
  output logic              killStrobe,
  output logic              resetStrobe,
  output logic              abortStrobe,
  output lockStrb_t         strb
);
  logic busyQ, pendQ;
  logic ctrlWr, isReset, isKill, isAbortCode, rejected, launchNow, abortReq, abortFire;

  always_comb begin
    ctrlWr      = wrEn && (wrAddr == ADDR_W'(CTRL_IDX));
    isReset     = ctrlWr && wrData[RST_BIT];
    isKill      = ctrlWr && !isReset && (!wrData[EN_BIT] || !wrData[CMD_MSB]);
    isAbortCode = ctrlWr && !isReset && !isKill && (wrData[1:0] == 2'b00);
    rejected    = busyQ && ctrlWr && !isReset && !isKill && !isAbortCode;
    launchNow   = !busyQ && ctrlWr && !isReset && !isKill;
    abortReq    = busyQ && isAbortCode;
    abortFire   = busyQ && byteDone && (pendQ || abortReq);
  end

  always_comb begin
    strb.lockOpen = !busyQ;
    strb.fieldWr  = ctrlWr && !isReset && !rejected;
    strb.swReset  = isReset;
    strb.ovrSet   = rejected;
    strb.ovrClr   = wrEn && (wrAddr == ADDR_W'(ERR_ADDR)) && wrData[OVR_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ       <= 1'b0;
      pendQ       <= 1'b0;
      cmdLaunch   <= 1'b0;
      launchCode  <= '0;
      killStrobe  <= 1'b0;
      resetStrobe <= 1'b0;
      abortStrobe <= 1'b0;
    end else begin
      if (isReset || isKill)  busyQ <= 1'b0;
      else if (txStart)       busyQ <= 1'b1;
      else if (byteDone)      busyQ <= 1'b0;

      if (isReset || isKill)  pendQ <= 1'b0;
      else if (abortFire)     pendQ <= 1'b0;
      else if (abortReq)      pendQ <= 1'b1;

      cmdLaunch   <= launchNow;
      if (launchNow) launchCode <= wrData[2:0];
      killStrobe  <= isKill;
      resetStrobe <= isReset;
      abortStrobe <= abortFire;
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/lock_dpath.sv
module lock_dpath
  import cmd_lock_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int NUM_LOCK = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  lockStrb_t                  strb,
  output logic [NUM_LOCK-1:0]        regWrEn,
  output logic [NUM_LOCK*DATA_W-1:0] regImage,
  output logic                       ovrErr
);
  localparam logic [DATA_W-1:0] FMASK = DATA_W'(FIELD_MASK);
  localparam logic [DATA_W-1:0] SMASK = DATA_W'(SPARE_MASK);

  for (genvar i = 0; i < NUM_LOCK; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    assign regWrEn[i] = wrEn && (wrAddr == ADDR_W'(i)) && strb.lockOpen && !strb.swReset;
    assign regImage[i*DATA_W +: DATA_W] = q;

    if (i == CTRL_IDX) begin : g_ctrl
      logic [DATA_W-1:0] nxt;
      always_comb begin
        nxt = q;
        if (regWrEn[i]) nxt = (nxt & ~SMASK) | (wrData & SMASK);
        if (strb.fieldWr) nxt = (nxt & ~FMASK) | (wrData & FMASK);
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             q <= '0;
        else if (strb.swReset) q <= '0;
        else                   q <= nxt;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             q <= '0;
        else if (strb.swReset) q <= '0;
        else if (regWrEn[i])   q <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ovrErr <= 1'b0;
    else if (strb.swReset) ovrErr <= 1'b0;
    else if (strb.ovrSet)  ovrErr <= 1'b1;
    else if (strb.ovrClr)  ovrErr <= 1'b0;
  end
endmodule

// File: rtl/cmd_lock_arbiter.sv
module cmd_lock_arbiter
  import cmd_lock_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int NUM_LOCK = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       txStart,
  input  logic                       byteDone,
  output logic                       busy,
  output logic [NUM_LOCK-1:0]        regWrEn,
  output logic [NUM_LOCK*DATA_W-1:0] regImage,
  output logic                       cmdLaunch,
  output logic [2:0]                 launchCode,
  output logic                       killStrobe,
  output logic                       resetStrobe,
  output logic                       abortStrobe,
  output logic                       ovrErr
);
  lockStrb_t strb;

  lock_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txStart(txStart), .byteDone(byteDone), .busy(busy),
    .cmdLaunch(cmdLaunch), .launchCode(launchCode), .killStrobe(killStrobe),
    .resetStrobe(resetStrobe), .abortStrobe(abortStrobe), .strb(strb)
  );

  lock_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOCK(NUM_LOCK)) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .regWrEn(regWrEn), .regImage(regImage), .ovrErr(ovrErr)
  );
endmodule

// File: rtl/cmd_lock_arbiter_chk.sv
module cmd_lock_arbiter_chk #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int NUM_LOCK = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [DATA_W-1:0]          wrData,
  input logic                       txStart,
  input logic                       byteDone,
  input logic                       busy,
  input logic [NUM_LOCK-1:0]        regWrEn,
  input logic [NUM_LOCK*DATA_W-1:0] regImage,
  input logic                       cmdLaunch,
  input logic [2:0]                 launchCode,
  input logic                       killStrobe,
  input logic                       resetStrobe,
  input logic                       abortStrobe,
  input logic                       ovrErr
);
  logic ctlW, rstW, killW, clrW;
  assign ctlW  = wrEn && (wrAddr == '0);
  assign rstW  = ctlW && wrData[7];
  assign killW = ctlW && !wrData[7] && (!wrData[3] || !wrData[2]);
  assign clrW  = wrEn && (wrAddr == ADDR_W'(6)) && wrData[0];

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    txStart && !rstW && !killW |=> busy); // R1
  AST_LOCKED_NO_WE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> regWrEn == '0); // R2
  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdLaunch |-> !$past(busy)); // R4
  AST_OVR_ON_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    busy && ctlW && !rstW && !killW && wrData[1:0] != 2'b00 |=> ovrErr && !cmdLaunch); // R5
  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    killStrobe |-> !busy); // R6
  AST_ABORT_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    abortStrobe |-> $past(byteDone)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    resetStrobe |-> !busy && !ovrErr && regImage == '0); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovrErr && !clrW && !rstW |=> ovrErr); // R9
endmodule

bind cmd_lock_arbiter cmd_lock_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOCK(NUM_LOCK)) u_chk (.*);

// File: tb/tb_cmd_lock_arbiter.sv
module tb_cmd_lock_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        wrEn = 1'b0, txStart = 1'b0, byteDone = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        busy, cmdLaunch, killStrobe, resetStrobe, abortStrobe, ovrErr;
  logic [5:0]  regWrEn;
  logic [47:0] regImage;
  logic [2:0]  launchCode;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  typedef struct {
    string      req;
    logic       busy;
    logic [3:0] stb;   // launch, kill, reset, abort
    logic [2:0] code;
    logic       ovr;
  } exp_t;
  exp_t sbq[$];

  cmd_lock_arbiter dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected post-edge state pushed to scoreboard
  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                      input logic ts, input logic bd, input logic [5:0] eWe,
                      input logic eBusy, input logic [3:0] eStb, input logic [2:0] eCode,
                      input logic eOvr, input string req);
    exp_t it;
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d; txStart = ts; byteDone = bd;
    it.req = req; it.busy = eBusy; it.stb = eStb; it.code = eCode; it.ovr = eOvr;
    sbq.push_back(it);
    #1 check(req, "regWrEn", 48'(regWrEn), 48'(eWe));
    @(posedge clk);
    #1 wrEn = 0; wrAddr = '0; wrData = '0; txStart = 0; byteDone = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t it;
      it = sbq.pop_front();
      check(it.req, "busy/strobes/ovr",
            48'({busy, cmdLaunch, killStrobe, resetStrobe, abortStrobe, ovrErr}),
            48'({it.busy, it.stb, it.ovr}));
      if (it.stb[3]) check(it.req, "launchCode", 48'(launchCode), 48'(it.code));
    end
  end

  task automatic checkImg(input string req, input logic [47:0] exp);
    #2 check(req, "regImage", regImage, exp);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    check("R10", "reset outputs", 48'({busy, cmdLaunch, killStrobe, resetStrobe, abortStrobe, ovrErr}), 48'(0));
    check("R10", "reset image", regImage, 48'(0));

    step(1, 3'd1, 8'h3C, 0, 0, 6'b000010, 0, 4'b0000, 3'd0, 0, "R2");
    step(1, 3'd4, 8'h2A, 0, 0, 6'b010000, 0, 4'b0000, 3'd0, 0, "R2");
    step(1, 3'd0, 8'h5D, 0, 0, 6'b000001, 0, 4'b1000, 3'd5, 0, "R4");
    checkImg("R2", 48'h00_2A_00_00_3C_5D);
    step(0, 3'd0, 8'h00, 1, 0, 6'b000000, 1, 4'b0000, 3'd0, 0, "R1");
    step(1, 3'd1, 8'h99, 0, 0, 6'b000000, 1, 4'b0000, 3'd0, 0, "R2");
    step(1, 3'd5, 8'h77, 0, 0, 6'b000000, 1, 4'b0000, 3'd0, 0, "R2");
    checkImg("R2", 48'h00_2A_00_00_3C_5D);
    step(1, 3'd0, 8'h0E, 0, 0, 6'b000000, 1, 4'b0000, 3'd0, 1, "R5");
    checkImg("R5", 48'h00_2A_00_00_3C_5D);
    step(1, 3'd0, 8'h6C, 0, 0, 6'b000000, 1, 4'b0000, 3'd0, 1, "R7");
    checkImg("R3", 48'h00_2A_00_00_3C_5C);
    step(0, 3'd0, 8'h00, 0, 0, 6'b000000, 1, 4'b0000, 3'd0, 1, "R7");
    step(0, 3'd0, 8'h00, 0, 1, 6'b000000, 0, 4'b0001, 3'd0, 1, "R7");
    step(0, 3'd0, 8'h00, 0, 0, 6'b000000, 0, 4'b0000, 3'd0, 1, "R9");
    step(1, 3'd6, 8'h00, 0, 0, 6'b000000, 0, 4'b0000, 3'd0, 1, "R9");
    step(1, 3'd6, 8'h01, 0, 0, 6'b000000, 0, 4'b0000, 3'd0, 0, "R9");
    step(0, 3'd0, 8'h00, 1, 0, 6'b000000, 1, 4'b0000, 3'd0, 0, "R1");
    step(1, 3'd0, 8'h0C, 0, 0, 6'b000000, 1, 4'b0000, 3'd0, 0, "R7");
    step(1, 3'd0, 8'h08, 0, 0, 6'b000000, 0, 4'b0100, 3'd0, 0, "R6");
    step(0, 3'd0, 8'h00, 0, 1, 6'b000000, 0, 4'b0000, 3'd0, 0, "R6");
    checkImg("R3", 48'h00_2A_00_00_3C_58);
    step(0, 3'd0, 8'h00, 1, 0, 6'b000000, 1, 4'b0000, 3'd0, 0, "R1");
    step(0, 3'd0, 8'h00, 1, 1, 6'b000000, 1, 4'b0000, 3'd0, 0, "R1");
    step(1, 3'd0, 8'h07, 0, 0, 6'b000000, 0, 4'b0100, 3'd0, 0, "R6");
    checkImg("R6", 48'h00_2A_00_00_3C_57);
    step(0, 3'd0, 8'h00, 1, 0, 6'b000000, 1, 4'b0000, 3'd0, 0, "R1");
    step(1, 3'd0, 8'h0F, 0, 0, 6'b000000, 1, 4'b0000, 3'd0, 1, "R5");
    step(1, 3'd0, 8'h80, 0, 0, 6'b000000, 0, 4'b0010, 3'd0, 0, "R8");
    checkImg("R8", 48'h0);
    step(0, 3'd0, 8'h00, 0, 0, 6'b000000, 0, 4'b0000, 3'd0, 0, "R8");
    step(1, 3'd0, 8'h85, 1, 0, 6'b000000, 0, 4'b0010, 3'd0, 0, "R8");
    step(1, 3'd0, 8'h0C, 0, 0, 6'b000001, 0, 4'b1000, 3'd4, 0, "R4");
    checkImg("R4", 48'h00_00_00_00_00_0C);
    step(0, 3'd0, 8'h00, 1, 0, 6'b000000, 1, 4'b0000, 3'd0, 0, "R1");
    step(1, 3'd0, 8'h0C, 0, 1, 6'b000000, 0, 4'b0001, 3'd0, 0, "R7");
    step(0, 3'd0, 8'h00, 0, 0, 6'b000000, 0, 4'b0000, 3'd0, 0, "R7");
    repeat (2) @(posedge clk);
    #3 summary();
  end
endmodule